// File: doc/BRIEF.md
# Four-Output Phase-Programmable PWM Timer

This block is a 16-bit up-counter that runs from zero to a programmable limit and then starts again at zero, which gives a period of limit + 1 counted steps. The counter advances only on cycles where both the enable and the tick strobe are high. A slower tick strobe therefore works as a prescaler. Eight compare values are arranged as four pairs, and each pair drives one output. When the counter reaches the first value of a pair, that output rises. When it reaches the second value, the output falls.

Each output has its own rise point and its own fall point, so a waveform can be placed anywhere in the period. The same block can produce edge-aligned PWM (every rise at zero), phase-shifted PWM, pulses that span the wrap, and quadrature pairs (two outputs whose rise points differ by a quarter period).

Software writes the limit and the compare values through a simple write port. Each write lands in a staging copy of the register. The values in use are refreshed from the staging copies only at the wrap, or on any cycle while the timer is disabled, so a period is never cut short or torn.

Top module: `pwm_multi_gen`

## Requirements
- R1: On a clock edge with `en` and `tick` both high, `count` increases by one, unless R2 applies. With `en` high and `tick` low, `count` keeps its value.
- R2: On a clock edge with `en` and `tick` high and `count` equal to the active limit, `count` becomes 0. `count` never exceeds the active limit.
- R3: Write address 2k (k = 0..3) holds the rise value of output k. On a cycle with `en` high, the rise value differing from the fall value and `count` equal to the rise value, `pwm_out[k]` is 1 after the next clock edge.
- R4: Write address 2k+1 holds the fall value of output k. On a cycle with `en` high, the fall value differing from the rise value and `count` equal to the fall value, `pwm_out[k]` is 0 after the next clock edge.
- R5: When the active rise and fall values of an output are equal and `en` is high, that output keeps its level.
- R6: Write address 8 holds the limit. Every write goes to a staging copy. The active limit and compare values are loaded from the staging copies at the clock edge of a wrap (the R2 condition), or at any edge where `en` is low. A write issued in the wrap cycle itself waits for the following load.
- R7: A write to addresses 9 to 15 changes nothing.
- R8: At a clock edge where `en` is low, `count` becomes 0 and all outputs become low.
- R9: Synchronous reset `rst` clears `count`, the outputs and all compare values to 0, and sets both copies of the limit to 0xFFFF.
- R10: With a shared limit, two outputs whose rise and fall values are offset by the same amount produce identical waveforms, shifted by that many counted steps (quadrature when the offset is a quarter period). A rise value above the fall value gives a high pulse that spans the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timer enable. When low, the counter is cleared and the outputs are forced low |
| tick | input | 1 | Count strobe, qualified by `en` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0..7 compare values, 8 limit |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| pwm_out | output | 4 | Registered PWM outputs |

## Verification
A wrong counter state shows on `count` at the very next edge. Because all four outputs compare against that counter, the same fault also moves every following edge of `pwm_out`. A wrongly staged compare or limit value does not appear at once. It appears one wrap later, as an edge in the wrong place or as a period of the wrong length. For that reason the bench keeps comparing for several full periods after each write. A channel that mishandles its hold case keeps the wrong level for a whole period, until its next matching count, so every cycle is compared against a behavioural model rather than only the edges.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;

  // Per-cycle decision taken by one output channel.
  typedef enum logic [1:0] {
    EV_KEEP = 2'd0,
    EV_RISE = 2'd1,
    EV_FALL = 2'd2
  } chan_ev_e;

  // Equal rise and fall points disable both events.
  function automatic chan_ev_e pick_event(input logic hit_rise,
                                          input logic hit_fall,
                                          input logic same_pts);
    if (same_pts)      return EV_KEEP;
    else if (hit_rise) return EV_RISE;
    else if (hit_fall) return EV_FALL;
    else               return EV_KEEP;
  endfunction

endpackage

// File: rtl/pwm_multi_regs.sv
module pwm_multi_regs #(
  parameter int CNT_W   = 16,
  parameter int N_OUT   = 4,
  parameter int ADDR_W  = 4,
  parameter logic [CNT_W-1:0] LIM_INIT = '1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [CNT_W-1:0]             wr_data,
  input  logic                         load,
  output logic [CNT_W-1:0]             lim_act,
  output logic [N_OUT-1:0][CNT_W-1:0]  rise_act,
  output logic [N_OUT-1:0][CNT_W-1:0]  fall_act
);

  localparam int N_CMP    = 2 * N_OUT;
  localparam int LIM_ADDR = N_CMP;

  logic [CNT_W-1:0] lim_stage;
  logic [CNT_W-1:0] cmp_stage [N_CMP];
  logic [CNT_W-1:0] cmp_live  [N_CMP];

  // Limit: staging copy written by software, live copy refreshed on load.
  always_ff @(posedge clk) begin
    if (rst) begin
      lim_stage <= LIM_INIT;
      lim_act   <= LIM_INIT;
    end else begin
      if (load)
        lim_act <= lim_stage;
      if (wr_en && (wr_addr == ADDR_W'(LIM_ADDR)))
        lim_stage <= wr_data;
    end
  end

  // Compare values, one staging/live pair per address.
  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_stage[i] <= '0;
        cmp_live[i]  <= '0;
      end else begin
        if (load)
          cmp_live[i] <= cmp_stage[i];
        if (wr_en && (wr_addr == ADDR_W'(i)))
          cmp_stage[i] <= wr_data;
      end
    end
  end

  // Even address = rise point, odd address = fall point.
  for (genvar k = 0; k < N_OUT; k++) begin : g_pair
    assign rise_act[k] = cmp_live[2*k];
    assign fall_act[k] = cmp_live[2*k+1];
  end

endmodule

// File: rtl/pwm_multi_cnt.sv
module pwm_multi_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  assign wrap = en && tick && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !en)
      cnt <= '0;
    else if (tick)
      cnt <= wrap ? '0 : cnt + CNT_W'(1);
  end

endmodule

// File: rtl/pwm_multi_chan.sv
module pwm_multi_chan
  import pwm_multi_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rise_pt,
  input  logic [CNT_W-1:0] fall_pt,
  output logic             wave
);

  chan_ev_e ev;

  always_comb begin
    ev = pick_event(cnt == rise_pt, cnt == fall_pt, rise_pt == fall_pt);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wave <= 1'b0;
    end else begin
      case (ev)
        EV_RISE: wave <= 1'b1;
        EV_FALL: wave <= 1'b0;
        default: wave <= wave;
      endcase
    end
  end

endmodule

// File: rtl/pwm_multi_gen.sv
module pwm_multi_gen #(
  parameter int CNT_W = 16,
  parameter int N_OUT = 4,
  localparam int ADDR_W = $clog2(2 * N_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic [N_OUT-1:0]  pwm_out
);

  logic [CNT_W-1:0]            lim_act;
  logic [N_OUT-1:0][CNT_W-1:0] rise_act;
  logic [N_OUT-1:0][CNT_W-1:0] fall_act;
  logic                        wrap;
  logic                        load;

  // Live values follow staging while idle, and only at the wrap while running.
  assign load = !en || wrap;

  pwm_multi_regs #(
    .CNT_W (CNT_W),
    .N_OUT (N_OUT),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .load    (load),
    .lim_act (lim_act),
    .rise_act(rise_act),
    .fall_act(fall_act)
  );

  pwm_multi_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .tick(tick),
    .lim (lim_act),
    .cnt (count),
    .wrap(wrap)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_chan
    pwm_multi_chan #(
      .CNT_W(CNT_W)
    ) u_chan (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .cnt    (count),
      .rise_pt(rise_act[k]),
      .fall_pt(fall_act[k]),
      .wave   (pwm_out[k])
    );
  end

endmodule

// File: rtl/pwm_multi_gen_chk.sv
module pwm_multi_gen_chk #(
  parameter int CNT_W = 16,
  parameter int N_OUT = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        en,
  input logic                        tick,
  input logic [CNT_W-1:0]            cnt,
  input logic [CNT_W-1:0]            lim,
  input logic [N_OUT-1:0][CNT_W-1:0] rise_v,
  input logic [N_OUT-1:0][CNT_W-1:0] fall_v,
  input logic [N_OUT-1:0]            pwm
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && tick && cnt != lim) |=> (cnt == $past(cnt) + CNT_W'(1))); // R1

  AST_COUNT_IDLE_TICK: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(cnt)); // R1

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && tick && cnt == lim) |=> (cnt == '0)); // R2

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cnt <= lim)); // R2

  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (rst)
    (en && !(tick && cnt == lim)) |=> $stable(lim)); // R6

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0 && pwm == '0)); // R8

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    AST_RISE_EDGE: assert property (@(posedge clk) disable iff (rst)
      (en && rise_v[k] != fall_v[k] && cnt == rise_v[k]) |=> pwm[k]); // R3

    AST_FALL_EDGE: assert property (@(posedge clk) disable iff (rst)
      (en && rise_v[k] != fall_v[k] && cnt == fall_v[k]) |=> !pwm[k]); // R4

    AST_EQUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (en && rise_v[k] == fall_v[k]) |=> (pwm[k] == $past(pwm[k]))); // R5
  end

endmodule

bind pwm_multi_gen pwm_multi_gen_chk #(
  .CNT_W(CNT_W),
  .N_OUT(N_OUT)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (en),
  .tick  (tick),
  .cnt   (count),
  .lim   (lim_act),
  .rise_v(rise_act),
  .fall_v(fall_act),
  .pwm   (pwm_out)
);

// File: tb/tb_pwm_multi_gen.sv
`timescale 1ns/1ps
module tb_pwm_multi_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [3:0]  pwm_out;

  int checks = 0;
  int bad = 0;
  bit cmp_on = 1'b0;
  string phase = "R9";

  always #2 clk = ~clk;

  pwm_multi_gen dut (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .pwm_out(pwm_out)
  );

  // Behavioural reference model, written from the requirements.
  int m_cnt, m_lim_a, m_lim_s;
  int m_cmp_a[8];
  int m_cmp_s[8];
  bit [3:0] m_out;
  bit [3:0] n_out;
  bit m_wrap;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_lim_a = 65535; m_lim_s = 65535; m_out = '0;
      for (int i = 0; i < 8; i++) begin m_cmp_a[i] = 0; m_cmp_s[i] = 0; end
    end else begin
      m_wrap = en && tick && (m_cnt == m_lim_a);
      for (int k = 0; k < 4; k++) begin
        if (!en) n_out[k] = 1'b0;
        else if (m_cmp_a[2*k] == m_cmp_a[2*k+1]) n_out[k] = m_out[k];
        else if (m_cnt == m_cmp_a[2*k]) n_out[k] = 1'b1;
        else if (m_cnt == m_cmp_a[2*k+1]) n_out[k] = 1'b0;
        else n_out[k] = m_out[k];
      end
      m_out = n_out;
      if (!en) m_cnt = 0;
      else if (tick) m_cnt = m_wrap ? 0 : m_cnt + 1;
      if (!en || m_wrap) begin
        m_lim_a = m_lim_s;
        for (int i = 0; i < 8; i++) m_cmp_a[i] = m_cmp_s[i];
      end
      if (wr_en) begin
        if (int'(wr_addr) < 8) m_cmp_s[int'(wr_addr)] = int'(wr_data);
        else if (int'(wr_addr) == 8) m_lim_s = int'(wr_data);
      end
    end
  end

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (int'(count) != m_cnt || pwm_out != m_out) begin
        bad++;
        $display("FAIL %s: count=%0d pwm=%b expected count=%0d pwm=%b",
                 phase, count, pwm_out, m_cnt, m_out);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input int div);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = ((i % div) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 count", int'(count), 0);
    check("R9 pwm", int'(pwm_out), 0);
    cmp_on = 1'b1;

    // Program while idle: limit 7 (period 8).
    phase = "R6";
    wr(8, 7);
    wr(0, 0); wr(1, 4);   // out0 edge-aligned
    wr(2, 2); wr(3, 6);   // out1 quarter-period later (quadrature)
    wr(4, 5); wr(5, 1);   // out2 pulse spanning wrap
    wr(6, 3); wr(7, 3);   // out3 equal points, holds
    tick = 1'b1;
    en = 1'b1;
    @(negedge clk);
    check("R3 first rise count", int'(count), 1);
    check("R3 first rise pwm", int'(pwm_out), 1);
    phase = "R10";
    run(40, 1);
    phase = "R1";
    run(60, 3);
    run(30, 2);

    // Change staged values while running: they wait for the wrap.
    phase = "R6";
    wr(8, 11);
    wr(0, 8);
    wr(7, 9);
    run(50, 1);
    phase = "R7";
    wr(9, 0); wr(12, 1); wr(15, 2);
    run(30, 1);

    phase = "R8";
    en = 1'b0;
    @(negedge clk);
    check("R8 count", int'(count), 0);
    check("R8 pwm", int'(pwm_out), 0);

    // Limit zero: wraps on every tick.
    phase = "R2";
    wr(8, 0); wr(0, 0); wr(1, 1);
    en = 1'b1;
    run(10, 1);
    check("R2 count at zero limit", int'(count), 0);
    en = 1'b0;
    wr(8, 5); wr(2, 4); wr(3, 4);
    en = 1'b1;
    phase = "R5";
    run(30, 1);
    phase = "R4";
    wr(1, 3);
    run(25, 1);

    cmp_on = 1'b0;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule